// File: doc/BRIEF.md
# Dual-Clock 18-Bit FIFO with Rewind and Two Output Timings

This block passes 18-bit words from a write clock domain to an independent read clock domain through a power-of-two deep store. The default depth is 1024. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other domain through two flops. Full and the upper threshold flags are worked out on the write side. Empty and the lower threshold flag are worked out on the read side.

The output timing is fixed while the full reset is held.

- **Request mode:** a word appears only after a read request. The two status pins mean "full" and "empty".
- **Fall-through mode:** the oldest word is moved to the outputs without a request. The status pins then mean "room to write" and "word valid on the outputs".

A lighter reset clears the pointers and the output register but keeps the chosen mode. A rewind pulse on the read clock moves only the read pointer back to location zero, so data already written can be read a second time. The threshold offsets are supplied from outside the block and are held steady.

In this block, the "stored count" means words written but not yet taken out of the store. In fall-through mode, the word currently shown on the outputs is no longer counted. The write side and the read side each see their own count. Each count lags the other side's pointer by the two-flop crossing delay.

Top module: `fifo_dc_rt`

## Requirements
- R1: While `mrst_n` is low, both pointers and `dout` are cleared to zero. The mode is taken from `fwft_sel`: 0 selects request mode and 1 selects fall-through mode. The mode is kept after `mrst_n` rises.
- R2: In request mode, `full_ir` is 1 exactly when DEPTH words are stored, and `empty_or` is 1 exactly when nothing is stored. In fall-through mode, `full_ir` is 1 when at least one slot is free, and `empty_or` is 1 when `dout` holds a valid word.
- R3: In request mode, a `ren` sampled on a `rclk` edge while not empty places the oldest word on `dout` after that edge. Words come out in the order they were written.
- R4: A `wen` while full does not store its word or move the write pointer. A `ren` while empty (request mode) or while `empty_or` is 0 (fall-through mode) does not change `dout` or the read pointer.
- R5: In fall-through mode, a word written into an empty FIFO reaches `dout` without any `ren`, and `empty_or` rises in the same cycle. The word stays on `dout` until a `ren` consumes it. A `ren` then shows the next word, or drops `empty_or` if none is stored.
- R6: In request mode, a `rexmit` sampled on a `rclk` edge sets the read pointer to zero and leaves the write side unchanged. It also forces `empty_or` to 1 for the one `rclk` cycle after that edge. The next read returns the word in location zero.
- R7: In fall-through mode, a `rexmit` forces `empty_or` to 0 for two `rclk` cycles. After that, the word in location zero is fetched onto `dout` and `empty_or` returns to 1.
- R8: While `prst_n` is low, both pointers and `dout` are cleared, but the mode chosen at the last master reset is kept.
- R9: `half_n` is 0 when the write-side stored count is greater than DEPTH/2, and 1 otherwise.
- R10: `afull_n` is 0 when the write-side stored count is greater than DEPTH minus `af_off`, and 1 otherwise.
- R11: `aempty_n` is 0 when the read-side stored count is less than `ae_off`, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert; mode is sampled while it is low |
| prst_n | input | 1 | Partial reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode choice during master reset (1 = fall-through) |
| wen | input | 1 | Write request on `wclk` |
| din | input | 18 | Write data |
| ren | input | 1 | Read request on `rclk` |
| rexmit | input | 1 | Rewind the read pointer to zero on `rclk` |
| af_off | input | ADDR_W | Almost-full offset |
| ae_off | input | ADDR_W | Almost-empty offset |
| dout | output | 18 | Output data register |
| full_ir | output | 1 | Full (request mode) or room to write (fall-through mode) |
| empty_or | output | 1 | Empty (request mode) or output valid (fall-through mode) |
| half_n | output | 1 | Low when more than half full |
| afull_n | output | 1 | Low when almost full |
| aempty_n | output | 1 | Low when almost empty |

## Verification
The hardest condition to reach is a rewind while a fall-through word is already valid on `dout`. This requires a word to have been fetched and held, and then the pointer yanked back under it. The stimulus writes two words, consumes both, rewinds once to refetch location zero, and then rewinds a second time while that refetched word is being shown.

Filling all 1024 slots is the only way to see the half, almost-full and full boundaries. The full store is then drained to walk the almost-empty edge and to prove that a write attempted while full did not overwrite location zero.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dcf_mode_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n = stg_q[1];
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_in;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin_out[W-1] = s2_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ s2_q[i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wen,
  input  logic [AW:0]   rbin_s,
  input  logic [AW-1:0] af_off,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_ir,
  output logic          half_n,
  output logic          afull_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] CAP  = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  logic [AW:0] wbin_q, wbin_d, wgray_q, cnt;
  logic        full;

  assign cnt     = wbin_q - rbin_s;
  assign full    = (cnt == CAP);
  assign wr_fire = wen & ~full;

  always_comb begin
    wbin_d = wbin_q;
    if (wr_fire) wbin_d = wbin_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign full_ir = fwft ? ~full : full;
  assign half_n  = ~(cnt > HALF);
  assign afull_n = ~(cnt > (CAP - {1'b0, af_off}));

  a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && full) |=> (wbin_q == $past(wbin_q)));

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ren,
  input  logic          rexmit,
  input  logic [AW:0]   wbin_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout,
  output logic          empty_or,
  output logic          aempty_n
);
  logic [AW:0]   rbin_q, rbin_d, rgray_q, cnt;
  logic [DW-1:0] dout_q, dout_d;
  logic          or_q, or_d, hold_q;
  logic          mem_empty, std_pop, ff_pop, pop;

  assign cnt       = wbin_s - rbin_q;
  assign mem_empty = (cnt == '0);
  assign std_pop   = ~fwft & ren & ~mem_empty & ~rexmit & ~hold_q;
  assign ff_pop    = fwft & ~mem_empty & ~rexmit & ~hold_q & (~or_q | ren);
  assign pop       = std_pop | ff_pop;

  always_comb begin
    rbin_d = rbin_q;
    dout_d = dout_q;
    or_d   = or_q;
    if (rexmit)   rbin_d = '0;
    else if (pop) rbin_d = rbin_q + 1'b1;
    if (pop) dout_d = mem_q;
    if (!fwft || rexmit) or_d = 1'b0;
    else if (ff_pop)     or_d = 1'b1;
    else if (ren)        or_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      or_q    <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      dout_q  <= dout_d;
      or_q    <= or_d;
      hold_q  <= rexmit;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign dout     = dout_q;
  assign empty_or = fwft ? or_q : (mem_empty | hold_q);
  assign aempty_n = ~(cnt < {1'b0, ae_off});

  a_r4_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && ren && mem_empty && !rexmit) |=> $stable(rbin_q));

  a_r6_rewind_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rexmit |=> (rbin_q == '0));

  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && or_q && !ren && !rexmit) |=> (or_q && $stable(dout_q)));

  a_r7_ready_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && rexmit) |=> !empty_or);
endmodule

// File: rtl/fifo_dc_rt.sv
module fifo_dc_rt
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  input  logic              rexmit,
  input  logic [ADDR_W-1:0] af_off,
  input  logic [ADDR_W-1:0] ae_off,
  output logic [DATA_W-1:0] dout,
  output logic              full_ir,
  output logic              empty_or,
  output logic              half_n,
  output logic              afull_n,
  output logic              aempty_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic              any_rst_n, w_rst_n, r_rst_n, w_mrst_n, r_mrst_n;
  dcf_mode_e         wmode_q, rmode_q;
  logic [PW-1:0]     wgray, rgray, wbin_s, rbin_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;

  assign any_rst_n = mrst_n & prst_n;

  dcf_rst_sync u_wrst  (.clk(wclk), .arst_n(any_rst_n), .rst_n(w_rst_n));
  dcf_rst_sync u_rrst  (.clk(rclk), .arst_n(any_rst_n), .rst_n(r_rst_n));
  dcf_rst_sync u_wmrst (.clk(wclk), .arst_n(mrst_n),    .rst_n(w_mrst_n));
  dcf_rst_sync u_rmrst (.clk(rclk), .arst_n(mrst_n),    .rst_n(r_mrst_n));

  always_ff @(posedge wclk) begin
    if (!w_mrst_n) wmode_q <= dcf_mode_e'(fwft_sel);
  end

  always_ff @(posedge rclk) begin
    if (!r_mrst_n) rmode_q <= dcf_mode_e'(fwft_sel);
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= din;
  end
  assign mem_q = mem[raddr];

  dcf_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(r_rst_n), .gray_in(wgray), .bin_out(wbin_s));
  dcf_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(w_rst_n), .gray_in(rgray), .bin_out(rbin_s));

  dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(w_rst_n), .fwft(wmode_q == MODE_FWFT), .wen(wen),
    .rbin_s(rbin_s), .af_off(af_off), .wr_fire(wr_fire), .waddr(waddr),
    .wgray(wgray), .full_ir(full_ir), .half_n(half_n), .afull_n(afull_n));

  dcf_rd_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
    .clk(rclk), .rst_n(r_rst_n), .fwft(rmode_q == MODE_FWFT), .ren(ren),
    .rexmit(rexmit), .wbin_s(wbin_s), .ae_off(ae_off), .mem_q(mem_q),
    .raddr(raddr), .rgray(rgray), .dout(dout), .empty_or(empty_or),
    .aempty_n(aempty_n));

  a_r1_dout_cleared: assert property (@(posedge rclk)
    !r_rst_n |-> (dout == '0));
endmodule

// File: tb/sim_fifo_dc_rt.sv
module sim_fifo_dc_rt;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic mrst_n, prst_n, fwft_sel, wen, ren, rexmit;
  logic [17:0] din, dout;
  logic [AW-1:0] af_off, ae_off;
  logic full_ir, empty_or, half_n, afull_n, aempty_n;

  fifo_dc_rt #(.ADDR_W(AW), .DATA_W(18)) u0 (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wen(wen), .din(din), .ren(ren), .rexmit(rexmit), .af_off(af_off), .ae_off(ae_off),
    .dout(dout), .full_ir(full_ir), .empty_or(empty_or), .half_n(half_n),
    .afull_n(afull_n), .aempty_n(aempty_n));

  localparam logic [17:0] PAT [8] = '{18'h00001, 18'h3FFFE, 18'h2AAAA, 18'h15555,
                                      18'h00000, 18'h3FFFF, 18'h12345, 18'h0F0F0};

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [17:0] d);
    wen = 1'b1; din = d; tick(); wen = 1'b0;
  endtask

  task automatic rd();
    ren = 1'b1; tick(); ren = 1'b0;
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic do_mrst(input logic m);
    tick();
    mrst_n = 1'b0; fwft_sel = m;
    repeat (4) tick();
    mrst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    wrap_up();
  end

  initial begin
    int errs;
    mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; wen = 1'b0; ren = 1'b0;
    rexmit = 1'b0; din = '0; af_off = 10'd4; ae_off = 10'd4;

    // R1 R2: master reset into request mode
    do_mrst(1'b0);
    chk("R1 dout", dout, 0);
    chk("R2 full", full_ir, 0);
    chk("R2 empty", empty_or, 1);
    chk("R9 half", half_n, 1);
    chk("R10 afull", afull_n, 1);
    chk("R11 aempty", aempty_n, 0);

    // R3: vector table walk
    for (int i = 0; i < 8; i++) wr(PAT[i]);
    settle();
    chk("R2 not empty", empty_or, 0);
    chk("R11 aempty high", aempty_n, 1);
    for (int i = 0; i < 8; i++) begin
      rd();
      chk("R3 order", dout, PAT[i]);
    end
    chk("R2 empty again", empty_or, 1);

    // R4: read while empty
    rd();
    chk("R4 dout kept", dout, PAT[7]);
    wr(18'h155AA);
    settle();
    rd();
    chk("R4 no skip", dout, 18'h155AA);

    // R6: request-mode rewind
    rexmit = 1'b1; tick(); rexmit = 1'b0;
    chk("R6 forced empty", empty_or, 1);
    tick();
    chk("R6 empty released", empty_or, 0);
    rd();
    chk("R6 first word", dout, PAT[0]);

    // R9 R10 R2 R4: fill to capacity
    do_mrst(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(18'(i));
      if (i == 511)  chk("R9 at half", half_n, 1);
      if (i == 512)  chk("R9 above half", half_n, 0);
      if (i == 1019) chk("R10 at limit", afull_n, 1);
      if (i == 1020) chk("R10 above limit", afull_n, 0);
      if (i == 1022) chk("R2 not full", full_ir, 0);
    end
    chk("R2 full", full_ir, 1);
    wr(18'h3FFFF);
    chk("R4 still full", full_ir, 1);
    settle();
    errs = 0;
    for (int j = 0; j < DEPTH; j++) begin
      rd();
      if (dout !== 18'(j)) errs++;
      if (j == 1019) chk("R11 at offset", aempty_n, 1);
      if (j == 1020) chk("R11 below offset", aempty_n, 0);
    end
    chk("R4 drain order", errs, 0);
    chk("R4 last word", dout, 18'd1023);
    chk("R2 drained", empty_or, 1);

    // R5 R2: fall-through mode
    do_mrst(1'b1);
    chk("R2 input ready", full_ir, 1);
    chk("R2 output not ready", empty_or, 0);
    chk("R1 dout fwft", dout, 0);
    wr(18'h0A0A1);
    settle();
    chk("R5 ready", empty_or, 1);
    chk("R5 fell through", dout, 18'h0A0A1);
    wr(18'h0B0B2);
    settle();
    chk("R5 held", dout, 18'h0A0A1);
    rd();
    chk("R5 next", dout, 18'h0B0B2);
    chk("R5 still ready", empty_or, 1);
    rd();
    chk("R5 drained", empty_or, 0);
    rd();
    chk("R4 ignored fwft read", dout, 18'h0B0B2);

    // R7: fall-through rewind
    rexmit = 1'b1; tick(); rexmit = 1'b0;
    chk("R7 not ready 1", empty_or, 0);
    tick();
    chk("R7 not ready 2", empty_or, 0);
    tick();
    chk("R7 refetched", empty_or, 1);
    chk("R7 word zero", dout, 18'h0A0A1);
    rexmit = 1'b1; tick(); rexmit = 1'b0;
    chk("R7 forced low", empty_or, 0);
    repeat (2) tick();
    chk("R7 ready again", empty_or, 1);
    chk("R7 word zero again", dout, 18'h0A0A1);

    // R8: partial reset keeps fall-through mode
    fwft_sel = 1'b0;
    prst_n = 1'b0;
    repeat (4) tick();
    prst_n = 1'b1;
    repeat (4) tick();
    chk("R8 dout cleared", dout, 0);
    chk("R8 not ready", empty_or, 0);
    chk("R8 mode kept", full_ir, 1);
    wr(18'h0D0D4);
    settle();
    chk("R8 fall-through kept", empty_or, 1);
    chk("R8 data", dout, 18'h0D0D4);

    wrap_up();
  end
endmodule